// File: doc/BRIEF.md
# Ethernet transmit frame launcher

This block launches one Ethernet frame from a byte buffer that software has already filled. The buffer holds the whole frame image: seven preamble bytes and a start-of-frame delimiter at the front, the frame body, and four bytes reserved for the frame check sequence at the end. Software then writes the total byte count to a count register. A non-zero write starts a transmit attempt.

The attempt first checks the count against a lower and an upper bound. It then compares the eight header bytes of the buffer with the expected delimiter pattern. A frame that passes both checks is streamed out one byte per handshake on a valid/ready byte stream. The stream skips the eight header bytes and the four trailing check bytes, and the final byte carries a last flag. Every attempt ends with a one-cycle transmit interrupt. A rejected attempt also raises a one-cycle error flag in that cycle and leaves the count register holding the written value. A successful attempt clears the count register to zero.

Top module: `tx_frame_launcher`

## Requirements
- R1: After reset the count output reads 0, and tx_valid, tx_irq and tx_err are all low.
- R2: A count write while idle stores the written value, which the count output shows. A non-zero value starts an attempt. Writing 0 stores 0 and starts nothing, so no interrupt follows.
- R3: A count below MIN_LEN (default 64) is rejected. tx_irq and tx_err are high in the cycle right after the write, and no byte is streamed.
- R4: A count above MAX_LEN (default 1530) is rejected in the same way as in R3.
- R5: With an accepted count, the frame is rejected unless buffer bytes 0 to 6 all equal 0x55 and byte 7 equals 0xD5. Byte k is checked k+1 cycles after the write cycle. A mismatch at byte k raises tx_irq and tx_err k+2 cycles after the write, and no byte is streamed.
- R6: A valid frame streams buffer bytes 8 through count-5 in ascending address order, count-12 bytes in total. tx_last is high on the final byte only.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values into the next cycle.
- R8: Each attempt raises tx_irq for exactly one cycle. tx_err is high in that same cycle when the frame was rejected, and is low otherwise.
- R9: After a successful send, the count output reads 0 from the cycle after the interrupt. After a rejection, it keeps the written value.
- R10: A count write made while an attempt is in progress (from the write cycle up to and including the interrupt cycle) is ignored. The count output is unchanged, and no further attempt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Buffer byte write enable |
| buf_addr | input | $clog2(DEPTH) | Buffer byte write address |
| buf_wdata | input | 8 | Buffer byte write data |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | CNT_W | Count register write value |
| cnt_value | output | CNT_W | Current count register contents |
| tx_data | output | 8 | Streamed frame byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_last | output | 1 | Final byte of the frame |
| tx_irq | output | 1 | One-cycle end-of-attempt interrupt |
| tx_err | output | 1 | One-cycle rejection flag, high only together with tx_irq |

## Verification
The bench builds the block with a 256-byte buffer, MIN_LEN 64 and MAX_LEN 200. With these values, both length bounds and frames at the largest accepted size are cheap to run. Counts just outside each bound (63, 201) can be written, along with a count larger than the whole buffer. Random counts spread over 1 to 260 land on all three sides of the accepted window. Random sink stalls and header corruption at each of the eight positions exercise the stream hold rule and the per-byte rejection timing.

// File: rtl/tx_launch_pkg.sv
`timescale 1ns/1ps
package tx_launch_pkg;

    localparam int HDR_BYTES = 8;
    localparam int FCS_BYTES = 4;
    localparam int OVERHEAD  = HDR_BYTES + FCS_BYTES;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_SEND,
        ST_DONE
    } launch_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
        logic       valid;
    } beat_t;

    // Expected header byte at position idx (0..7)
    function automatic logic [7:0] hdr_expect(input logic [2:0] idx);
        return (idx == 3'd7) ? SFD_BYTE : PRE_BYTE;
    endfunction

endpackage

// File: rtl/tx_buf_ram.sv
`timescale 1ns/1ps
module tx_buf_ram #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read: header check and stream both see the byte in the same cycle
    assign rdata = mem[raddr];

endmodule

// File: rtl/tx_len_check.sv
`timescale 1ns/1ps
module tx_len_check #(
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1530
) (
    input  logic [CNT_W-1:0] len,
    output logic             len_ok
);

    localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_LEN);

    assign len_ok = (len >= LO) && (len <= HI);

endmodule

// File: rtl/tx_launch_ctrl.sv
`timescale 1ns/1ps
module tx_launch_ctrl
    import tx_launch_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AW    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             len_ok,
    input  logic [7:0]       rd_data,
    output logic [AW-1:0]    rd_addr,
    input  logic             tx_ready,
    output logic [CNT_W-1:0] cnt_value,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             tx_irq,
    output logic             tx_err
);

    launch_state_t    st;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] remain;
    logic [AW-1:0]    ptr;
    logic             fail_q;
    beat_t            beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt_q  <= '0;
            remain <= '0;
            ptr    <= '0;
            fail_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cnt_we) begin
                        cnt_q <= cnt_wdata;
                        if (cnt_wdata != '0) begin
                            ptr <= '0;
                            if (len_ok) begin
                                st     <= ST_HDR;
                                fail_q <= 1'b0;
                            end else begin
                                st     <= ST_DONE;
                                fail_q <= 1'b1;
                            end
                        end
                    end
                end
                ST_HDR: begin
                    if (rd_data != hdr_expect(ptr[2:0])) begin
                        st     <= ST_DONE;
                        fail_q <= 1'b1;
                    end else if (ptr == AW'(HDR_BYTES - 1)) begin
                        ptr    <= AW'(HDR_BYTES);
                        remain <= cnt_q - CNT_W'(OVERHEAD);
                        st     <= ST_SEND;
                    end else begin
                        ptr <= ptr + AW'(1);
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        ptr    <= ptr + AW'(1);
                        remain <= remain - CNT_W'(1);
                        if (remain == CNT_W'(1)) begin
                            st     <= ST_DONE;
                            fail_q <= 1'b0;
                        end
                    end
                end
                ST_DONE: begin
                    if (!fail_q) begin
                        cnt_q <= '0;
                    end
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        beat.valid = (st == ST_SEND);
        beat.last  = (st == ST_SEND) && (remain == CNT_W'(1));
        beat.data  = rd_data;
    end

    assign rd_addr   = ptr;
    assign cnt_value = cnt_q;
    assign tx_data   = beat.data;
    assign tx_valid  = beat.valid;
    assign tx_last   = beat.last;
    assign tx_irq    = (st == ST_DONE);
    assign tx_err    = (st == ST_DONE) && fail_q;

    // R8: interrupt lasts a single cycle
    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    // R8: error flag only together with the interrupt
    p_err_with_irq_r8: assert property (@(posedge clk) disable iff (rst)
        tx_err |-> tx_irq);

    // R7: stalled beat is held
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R6: accepted last byte ends the attempt successfully
    p_last_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> (tx_irq && !tx_err));

    // R10: count is untouched while checking or sending
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HDR || st == ST_SEND) |=> $stable(cnt_value));

    // R9: success clears the count
    p_clear_after_ok_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_irq && !tx_err) |=> (cnt_value == '0));

    // R9: rejection keeps the count
    p_keep_after_fail_r9: assert property (@(posedge clk) disable iff (rst)
        tx_err |=> $stable(cnt_value));

endmodule

// File: rtl/tx_frame_launcher.sv
`timescale 1ns/1ps
module tx_frame_launcher #(
    parameter int DEPTH   = 2048,
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1530,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             buf_we,
    input  logic [AW-1:0]    buf_addr,
    input  logic [7:0]       buf_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_value,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             tx_last,
    output logic             tx_irq,
    output logic             tx_err
);

    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          len_ok;

    tx_buf_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    tx_len_check #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
        .len    (cnt_wdata),
        .len_ok (len_ok)
    );

    tx_launch_ctrl #(.CNT_W(CNT_W), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .len_ok    (len_ok),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .tx_ready  (tx_ready),
        .cnt_value (cnt_value),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_irq    (tx_irq),
        .tx_err    (tx_err)
    );

endmodule

// File: tb/test_tx_frame_launcher.sv
`timescale 1ns/1ps
module test_tx_frame_launcher;

    localparam int DEPTH = 256;
    localparam int CW    = 16;
    localparam int MINL  = 64;
    localparam int MAXL  = 200;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          buf_we = 1'b0;
    logic [AW-1:0] buf_addr = '0;
    logic [7:0]    buf_wdata = '0;
    logic          cnt_we = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [CW-1:0] cnt_value;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic          tx_last;
    logic          tx_irq;
    logic          tx_err;

    int total = 0;
    int bad   = 0;
    logic [7:0] bmem [DEPTH];
    logic [7:0] got  [DEPTH];

    always #10 clk = ~clk;

    tx_frame_launcher #(.DEPTH(DEPTH), .CNT_W(CW), .MIN_LEN(MINL), .MAX_LEN(MAXL)) i_tx_frame_launcher (
        .clk(clk), .rst(rst), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
        .tx_irq(tx_irq), .tx_err(tx_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit len_ok_f(input int c);
        return (c >= MINL) && (c <= MAXL);
    endfunction

    // Fill buffer image; bad_idx in 0..7 corrupts that header byte
    task automatic fill(input int len, input int bad_idx);
        int n;
        n = (len > DEPTH) ? DEPTH : len;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            if (i < 7) b = 8'h55;
            else if (i == 7) b = 8'hD5;
            else b = 8'($urandom);
            if (i == bad_idx) b = b ^ (8'($urandom % 255) + 8'd1);
            @(negedge clk);
            buf_we = 1'b1; buf_addr = AW'(i); buf_wdata = b;
            bmem[i] = b;
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic attempt(input int cnt, input int bad_idx, input int ready_pct, input int inject_at);
        bit exp_ok, seen, err_seen, hold_bad, cnt_bad, prev_stall, prev_last, extra_irq;
        int exp_iter, irq_iter, got_n, last_pos, iter, mism;
        logic [7:0] prev_data;
        exp_ok = len_ok_f(cnt) && (bad_idx < 0);
        exp_iter = !len_ok_f(cnt) ? 0 : (bad_idx + 1);
        seen = 0; err_seen = 0; hold_bad = 0; cnt_bad = 0; prev_stall = 0; prev_last = 0;
        prev_data = '0; irq_iter = -1; got_n = 0; last_pos = -1; iter = 0;
        @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = CW'(cnt);
        @(negedge clk);
        cnt_we = 1'b0;
        while (!seen && iter < 3000) begin
            if (iter > 0) @(negedge clk);
            tx_ready = (($urandom % 100) < ready_pct);
            if (iter == inject_at) begin
                cnt_we = 1'b1; cnt_wdata = CW'(77 + ($urandom % 50));
            end else begin
                cnt_we = 1'b0;
            end
            #1;
            if (prev_stall && !(tx_valid && tx_data == prev_data && tx_last == prev_last)) hold_bad = 1;
            if (cnt_value != CW'(cnt)) cnt_bad = 1;
            if (tx_valid && tx_ready) begin
                if (got_n < DEPTH) got[got_n] = tx_data;
                if (tx_last) last_pos = got_n;
                got_n++;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
            if (tx_irq) begin
                seen = 1; irq_iter = iter; err_seen = tx_err;
            end
            iter++;
        end
        chk(seen, "R8 interrupt seen", int'(seen), 1);
        chk(err_seen == !exp_ok, "R8 err flag", int'(err_seen), int'(!exp_ok));
        chk(!cnt_bad, "R10 count stable during attempt", int'(cnt_bad), 0);
        if (!exp_ok) begin
            if (!len_ok_f(cnt))
                chk(irq_iter == exp_iter, (cnt < MINL) ? "R3 reject timing" : "R4 reject timing", irq_iter, exp_iter);
            else
                chk(irq_iter == exp_iter, "R5 header reject timing", irq_iter, exp_iter);
            chk(got_n == 0, "R5 no bytes on reject", got_n, 0);
        end else begin
            mism = 0;
            for (int k = 0; k < got_n && k < DEPTH; k++)
                if (got[k] != bmem[8 + k]) mism++;
            chk(got_n == cnt - 12, "R6 byte count", got_n, cnt - 12);
            chk(mism == 0, "R6 byte content", mism, 0);
            chk(last_pos == cnt - 13, "R6 last position", last_pos, cnt - 13);
            chk(!hold_bad, "R7 stall hold", int'(hold_bad), 0);
        end
        @(negedge clk);
        cnt_we = 1'b0;
        tx_ready = 1'b0;
        #1;
        chk(!tx_irq, "R8 single-cycle irq", int'(tx_irq), 0);
        chk(cnt_value == (exp_ok ? CW'(0) : CW'(cnt)), "R9 count after attempt",
            int'(cnt_value), exp_ok ? 0 : (cnt & 16'hFFFF));
        extra_irq = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk); #1;
            if (tx_irq || tx_valid) extra_irq = 1;
        end
        chk(!extra_irq, "R10 no further attempt", int'(extra_irq), 0);
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(cnt_value == '0, "R1 reset count", int'(cnt_value), 0);
        chk(!tx_valid && !tx_irq && !tx_err, "R1 reset outputs",
            int'({tx_valid, tx_irq, tx_err}), 0);

        // R3 / R4 length bounds
        attempt(MINL - 1, -1, 100, -1);
        attempt(1, -1, 100, -1);
        attempt(MAXL + 1, -1, 100, -1);
        attempt(16'hFFFF, -1, 100, -1);

        // R2 zero write: stores 0, no attempt
        begin
            bit any;
            @(negedge clk); cnt_we = 1'b1; cnt_wdata = '0;
            @(negedge clk); cnt_we = 1'b0;
            any = 0;
            for (int j = 0; j < 10; j++) begin
                #1; if (tx_irq || tx_valid) any = 1;
                @(negedge clk);
            end
            chk(cnt_value == '0, "R2 zero write stored", int'(cnt_value), 0);
            chk(!any, "R2 zero write starts nothing", int'(any), 0);
        end

        // R6 bounds of accepted sizes
        fill(MINL, -1);  attempt(MINL, -1, 100, -1);
        fill(MAXL, -1);  attempt(MAXL, -1, 50, -1);

        // R5 each header position
        for (int k = 0; k < 8; k++) begin
            fill(100, k);
            attempt(100, k, 100, (k == 7) ? 2 : -1);
        end

        // R10 write during send, R7 heavy stalls
        fill(120, -1);   attempt(120, -1, 30, 3);

        // Random mix
        for (int r = 0; r < 25; r++) begin
            int len, bidx, rp, inj;
            len  = 1 + int'($urandom % 260);
            bidx = (($urandom % 4) == 0) ? int'($urandom % 8) : -1;
            case ($urandom % 3)
                0: rp = 100;
                1: rp = 70;
                default: rp = 30;
            endcase
            inj = (len_ok_f(len) && ($urandom % 2 == 0)) ? 1 : -1;
            fill(len, bidx);
            attempt(len, bidx, rp, inj);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule